// File: doc/BRIEF.md
# Resumable NMI Enable and Trap Steering

This block keeps the single enable bit that gates resumable non-maskable interrupts in a small processor trap unit. Each cycle it decides whether a pending resumable NMI is taken, and it picks the address the front end should fetch from when a trap occurs. The three possible targets are the fixed handler for resumable NMIs, the fixed handler for exceptions raised while that enable is off, and the normal trap vector supplied by the surrounding trap unit. It also answers the wait-for-interrupt wake query.

Software can only set the enable bit. It is cleared at reset and whenever a resumable NMI is taken, so these interrupts never nest. A dedicated return-from-RNMI indication turns the bit back on. The ordinary machine and supervisor returns arrive on the same return-kind input but leave the bit untouched. The decision outputs are combinational from the current inputs and the bit. The bit is the only register in the block.

Top module: `rnmi_trap_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the enable bit is cleared, so `nmi_en_o` reads 0 after that edge.
- R2: A CSR write (`csr_wr_en`=1) with `csr_wr_nmie`=1 sets `nmi_en_o` to 1 after the next clock edge.
- R3: A CSR write with `csr_wr_nmie`=0 leaves `nmi_en_o` at its previous value, whether that value is 0 or 1.
- R4: Return kinds 1 (machine return) and 2 (supervisor return) on `ret_kind_i` do not change `nmi_en_o`, and they do not change whether an RNMI is taken. Kind 0 means no return.
- R5: `take_rnmi_o` is 1 in exactly the cycles where `rnmi_req_i`=1 and `nmi_en_o`=1. It is combinational, with no clock delay.
- R6: After a cycle with `take_rnmi_o`=1, `nmi_en_o` is 0. This clearing wins over a CSR set or an RNMI return in the same cycle.
- R7: Return kind 3 (return from RNMI) on `ret_kind_i` sets `nmi_en_o` to 1 after the next clock edge, unless R6 clears it in that cycle.
- R8: When `exc_valid_i`=1 and no RNMI is taken, `trap_target_o` equals `trap_vec_i` if `nmi_en_o`=1. If `nmi_en_o`=0, it equals parameter `RNMI_EXC_ADDR`.
- R9: When an RNMI is taken, `trap_target_o` equals parameter `RNMI_HANDLER_ADDR`, even if an exception arrives in the same cycle. `trap_valid_o` = `take_rnmi_o` OR `exc_valid_i`.
- R10: `wake_o` = `wfi_active_i` AND (`rnmi_req_i` OR `irq_pending_i`), independent of `nmi_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr_en | input | 1 | CSR write strobe for the RNMI status register |
| csr_wr_nmie | input | 1 | Value written to the enable field |
| ret_kind_i | input | 2 | Return retiring this cycle: 0 none, 1 machine, 2 supervisor, 3 from RNMI |
| rnmi_req_i | input | 1 | Resumable NMI request line |
| exc_valid_i | input | 1 | Synchronous exception raised this cycle |
| trap_vec_i | input | XLEN | Normal trap vector base |
| wfi_active_i | input | 1 | Core is waiting in WFI and queries wake-up |
| irq_pending_i | input | 1 | A locally enabled regular interrupt is pending |
| take_rnmi_o | output | 1 | RNMI is taken this cycle |
| trap_valid_o | output | 1 | A trap redirect is requested this cycle |
| trap_target_o | output | XLEN | Selected trap handler address |
| wake_o | output | 1 | Wake the core from WFI |
| nmi_en_o | output | 1 | Readable enable bit |

## Verification
The steering logic is driven with each combination of RNMI request and exception at both enable values. This separates three cases: the RNMI-handler target that wins a collision, the dedicated exception target used while the bit is off, and the normal vector. The enable bit is checked under writes of 0 and 1 from each starting value, under every return kind, and under a take that coincides with a set. These patterns tell a set-only register apart from a writable one, and a clear that has priority from one that loses. Wake is tried with the bit off, with only the regular interrupt pending, and with WFI inactive. This shows that the bit does not gate wake-up.

// File: rtl/rnmi_pkg.sv
package rnmi_pkg;

    typedef enum logic [1:0] {
        RET_NONE = 2'd0,
        RET_MACH = 2'd1,
        RET_SUPV = 2'd2,
        RET_RNMI = 2'd3
    } ret_kind_e;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_RNMI_HANDLER,
        TGT_RNMI_EXC,
        TGT_VECTOR
    } tgt_sel_e;

    typedef struct packed {
        logic rnmi_req;
        logic exc_valid;
    } trap_in_t;

    typedef struct packed {
        logic     take_rnmi;
        logic     valid;
        tgt_sel_e sel;
    } trap_dec_t;

    typedef struct packed {
        logic set_req;
        logic clr_req;
    } en_ctl_t;

    // Priority: taken RNMI first, then exception steered by enable state.
    function automatic trap_dec_t decide_trap(trap_in_t in, logic en);
        trap_dec_t d;
        d.take_rnmi = in.rnmi_req & en;
        d.valid     = d.take_rnmi | in.exc_valid;
        if (d.take_rnmi)
            d.sel = TGT_RNMI_HANDLER;
        else if (in.exc_valid)
            d.sel = en ? TGT_VECTOR : TGT_RNMI_EXC;
        else
            d.sel = TGT_NONE;
        return d;
    endfunction

endpackage

// File: rtl/rnmi_en_state.sv
module rnmi_en_state
    import rnmi_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  en_ctl_t ctl,
    output logic    en
);
    logic en_q;

    // Clear dominates set; no path lets software clear the bit.
    always_ff @(posedge clk) begin
        if (rst)
            en_q <= 1'b0;
        else if (ctl.clr_req)
            en_q <= 1'b0;
        else if (ctl.set_req)
            en_q <= 1'b1;
    end

    assign en = en_q;
endmodule

// File: rtl/rnmi_trap_steer.sv
module rnmi_trap_steer
    import rnmi_pkg::*;
#(
    parameter int          XLEN              = 32,
    parameter logic [XLEN-1:0] RNMI_HANDLER_ADDR = 32'h0000_1000,
    parameter logic [XLEN-1:0] RNMI_EXC_ADDR     = 32'h0000_1100
) (
    input  trap_in_t        req,
    input  logic            en,
    input  logic [XLEN-1:0] vec,
    output trap_dec_t       dec,
    output logic [XLEN-1:0] target
);
    always_comb begin
        dec = decide_trap(req, en);
        unique case (dec.sel)
            TGT_RNMI_HANDLER: target = RNMI_HANDLER_ADDR;
            TGT_RNMI_EXC:     target = RNMI_EXC_ADDR;
            TGT_VECTOR:       target = vec;
            default:          target = '0;
        endcase
    end
endmodule

// File: rtl/rnmi_wake_detect.sv
module rnmi_wake_detect (
    input  logic wfi_active,
    input  logic rnmi_req,
    input  logic irq_pending,
    output logic wake
);
    // Enable bit deliberately absent: it only gates taking, not waking.
    assign wake = wfi_active & (rnmi_req | irq_pending);
endmodule

// File: rtl/rnmi_trap_ctrl.sv
module rnmi_trap_ctrl
    import rnmi_pkg::*;
#(
    parameter int              XLEN              = 32,
    parameter logic [XLEN-1:0] RNMI_HANDLER_ADDR = 32'h0000_1000,
    parameter logic [XLEN-1:0] RNMI_EXC_ADDR     = 32'h0000_1100
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            csr_wr_en,
    input  logic            csr_wr_nmie,
    input  logic [1:0]      ret_kind_i,
    input  logic            rnmi_req_i,
    input  logic            exc_valid_i,
    input  logic [XLEN-1:0] trap_vec_i,
    input  logic            wfi_active_i,
    input  logic            irq_pending_i,
    output logic            take_rnmi_o,
    output logic            trap_valid_o,
    output logic [XLEN-1:0] trap_target_o,
    output logic            wake_o,
    output logic            nmi_en_o
);
    ret_kind_e ret_kind;
    trap_in_t  trap_in;
    trap_dec_t trap_dec;
    en_ctl_t   en_ctl;
    logic      en;

    assign ret_kind          = ret_kind_e'(ret_kind_i);
    assign trap_in.rnmi_req  = rnmi_req_i;
    assign trap_in.exc_valid = exc_valid_i;

    rnmi_trap_steer #(
        .XLEN              (XLEN),
        .RNMI_HANDLER_ADDR (RNMI_HANDLER_ADDR),
        .RNMI_EXC_ADDR     (RNMI_EXC_ADDR)
    ) steer_i (
        .req    (trap_in),
        .en     (en),
        .vec    (trap_vec_i),
        .dec    (trap_dec),
        .target (trap_target_o)
    );

    // Machine and supervisor returns are decoded as no-ops for the bit.
    assign en_ctl.set_req = (csr_wr_en & csr_wr_nmie) | (ret_kind == RET_RNMI);
    assign en_ctl.clr_req = trap_dec.take_rnmi;

    rnmi_en_state en_i (
        .clk (clk),
        .rst (rst),
        .ctl (en_ctl),
        .en  (en)
    );

    rnmi_wake_detect wake_i (
        .wfi_active  (wfi_active_i),
        .rnmi_req    (rnmi_req_i),
        .irq_pending (irq_pending_i),
        .wake        (wake_o)
    );

    assign take_rnmi_o  = trap_dec.take_rnmi;
    assign trap_valid_o = trap_dec.valid;
    assign nmi_en_o     = en;
endmodule

// File: rtl/rnmi_trap_ctrl_chk.sv
module rnmi_trap_ctrl_chk #(
    parameter int              XLEN              = 32,
    parameter logic [XLEN-1:0] RNMI_HANDLER_ADDR = 32'h0000_1000,
    parameter logic [XLEN-1:0] RNMI_EXC_ADDR     = 32'h0000_1100
) (
    input logic            clk,
    input logic            rst,
    input logic            csr_wr_en,
    input logic            csr_wr_nmie,
    input logic [1:0]      ret_kind_i,
    input logic            rnmi_req_i,
    input logic            exc_valid_i,
    input logic [XLEN-1:0] trap_vec_i,
    input logic            wfi_active_i,
    input logic            irq_pending_i,
    input logic            take_rnmi_o,
    input logic            trap_valid_o,
    input logic [XLEN-1:0] trap_target_o,
    input logic            wake_o,
    input logic            nmi_en_o
);
    logic any_set;
    assign any_set = (csr_wr_en & csr_wr_nmie) | (ret_kind_i == 2'd3);

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !nmi_en_o); // R1
    AST_CSR_SETS: assert property (@(posedge clk) disable iff (rst)
        csr_wr_en && csr_wr_nmie && !take_rnmi_o |=> nmi_en_o); // R2
    AST_CSR_ZERO_HOLDS: assert property (@(posedge clk) disable iff (rst)
        csr_wr_en && !csr_wr_nmie && !take_rnmi_o && ret_kind_i != 2'd3
        |=> $stable(nmi_en_o)); // R3
    AST_XRET_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (ret_kind_i == 2'd1 || ret_kind_i == 2'd2) && !take_rnmi_o && !csr_wr_en
        |=> $stable(nmi_en_o)); // R4
    AST_TAKE_GATED: assert property (@(posedge clk) disable iff (rst)
        take_rnmi_o == (rnmi_req_i && nmi_en_o)); // R5
    AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        take_rnmi_o |=> !nmi_en_o); // R6
    AST_RESUME_SETS: assert property (@(posedge clk) disable iff (rst)
        ret_kind_i == 2'd3 && !take_rnmi_o |=> nmi_en_o); // R7
    AST_EXC_STEER: assert property (@(posedge clk) disable iff (rst)
        exc_valid_i && !take_rnmi_o
        |-> trap_target_o == (nmi_en_o ? trap_vec_i : RNMI_EXC_ADDR)); // R8
    AST_RNMI_TARGET: assert property (@(posedge clk) disable iff (rst)
        take_rnmi_o |-> trap_target_o == RNMI_HANDLER_ADDR && trap_valid_o); // R9
    AST_WAKE_UNGATED: assert property (@(posedge clk) disable iff (rst)
        wake_o == (wfi_active_i && (rnmi_req_i || irq_pending_i))); // R10
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
        !nmi_en_o && !any_set |=> !nmi_en_o); // R3
endmodule

bind rnmi_trap_ctrl rnmi_trap_ctrl_chk #(
    .XLEN              (XLEN),
    .RNMI_HANDLER_ADDR (RNMI_HANDLER_ADDR),
    .RNMI_EXC_ADDR     (RNMI_EXC_ADDR)
) chk_i (
    .clk           (clk),
    .rst           (rst),
    .csr_wr_en     (csr_wr_en),
    .csr_wr_nmie   (csr_wr_nmie),
    .ret_kind_i    (ret_kind_i),
    .rnmi_req_i    (rnmi_req_i),
    .exc_valid_i   (exc_valid_i),
    .trap_vec_i    (trap_vec_i),
    .wfi_active_i  (wfi_active_i),
    .irq_pending_i (irq_pending_i),
    .take_rnmi_o   (take_rnmi_o),
    .trap_valid_o  (trap_valid_o),
    .trap_target_o (trap_target_o),
    .wake_o        (wake_o),
    .nmi_en_o      (nmi_en_o)
);

// File: tb/rnmi_trap_ctrl_tb_top.sv
`timescale 1ns/1ps
module rnmi_trap_ctrl_tb_top;
    localparam int          XLEN = 32;
    localparam logic [31:0] HADDR = 32'h0000_1000;
    localparam logic [31:0] EADDR = 32'h0000_1100;
    localparam logic [31:0] VEC   = 32'h8000_0040;

    logic            clk = 1'b0;
    logic            rst;
    logic            csr_wr_en, csr_wr_nmie;
    logic [1:0]      ret_kind;
    logic            rnmi_req, exc_valid, wfi_active, irq_pending;
    logic [XLEN-1:0] trap_vec;
    logic            take_rnmi, trap_valid, wake, nmi_en;
    logic [XLEN-1:0] trap_target;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    rnmi_trap_ctrl #(
        .XLEN (XLEN), .RNMI_HANDLER_ADDR (HADDR), .RNMI_EXC_ADDR (EADDR)
    ) dut_i (
        .clk (clk), .rst (rst), .csr_wr_en (csr_wr_en), .csr_wr_nmie (csr_wr_nmie),
        .ret_kind_i (ret_kind), .rnmi_req_i (rnmi_req), .exc_valid_i (exc_valid),
        .trap_vec_i (trap_vec), .wfi_active_i (wfi_active), .irq_pending_i (irq_pending),
        .take_rnmi_o (take_rnmi), .trap_valid_o (trap_valid), .trap_target_o (trap_target),
        .wake_o (wake), .nmi_en_o (nmi_en)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        csr_wr_en = 0; csr_wr_nmie = 0; ret_kind = 2'd0;
        rnmi_req = 0; exc_valid = 0; wfi_active = 0; irq_pending = 0;
    endtask

    // Inputs change 1 ns after an edge; outputs are read 1 ns later.
    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic do_reset();
        idle(); rst = 1;
        step(); step();
        chk("R1 enable after reset", {31'b0, nmi_en}, 32'd0);
        rnmi_req = 1; settle();
        chk("R5 no take while reset-masked", {31'b0, take_rnmi}, 32'd0);
        rst = 0; idle();
    endtask

    task automatic t_csr();
        csr_wr_en = 1; csr_wr_nmie = 0; step(); idle();
        chk("R3 write 0 from 0", {31'b0, nmi_en}, 32'd0);
        csr_wr_en = 1; csr_wr_nmie = 1; step(); idle();
        chk("R2 write 1 sets", {31'b0, nmi_en}, 32'd1);
        csr_wr_en = 1; csr_wr_nmie = 0; step(); idle();
        chk("R3 write 0 from 1 ignored", {31'b0, nmi_en}, 32'd1);
    endtask

    task automatic t_xret();
        ret_kind = 2'd1; step(); idle();
        chk("R4 machine return keeps 1", {31'b0, nmi_en}, 32'd1);
        ret_kind = 2'd2; step(); idle();
        chk("R4 supervisor return keeps 1", {31'b0, nmi_en}, 32'd1);
        ret_kind = 2'd1; rnmi_req = 1; settle();
        chk("R4 take unaffected by return", {31'b0, take_rnmi}, 32'd1);
        step(); idle();
        chk("R6 cleared after take", {31'b0, nmi_en}, 32'd0);
        ret_kind = 2'd2; step(); idle();
        chk("R4 supervisor return keeps 0", {31'b0, nmi_en}, 32'd0);
    endtask

    task automatic t_take();
        ret_kind = 2'd3; step(); idle();
        chk("R7 resume sets", {31'b0, nmi_en}, 32'd1);
        rnmi_req = 1; settle();
        chk("R5 take when enabled", {31'b0, take_rnmi}, 32'd1);
        chk("R9 rnmi target", trap_target, HADDR);
        chk("R9 trap valid on take", {31'b0, trap_valid}, 32'd1);
        step();
        chk("R6 enable cleared", {31'b0, nmi_en}, 32'd0);
        chk("R5 no nested take", {31'b0, take_rnmi}, 32'd0);
        chk("R9 no trap without exc", {31'b0, trap_valid}, 32'd0);
        idle();
    endtask

    task automatic t_exc();
        exc_valid = 1; trap_vec = VEC; settle();
        chk("R8 exc with enable 0", trap_target, EADDR);
        chk("R9 trap valid on exc", {31'b0, trap_valid}, 32'd1);
        rnmi_req = 1; settle();
        chk("R8 exc+req with enable 0", trap_target, EADDR);
        idle(); ret_kind = 2'd3; step(); idle();
        exc_valid = 1; settle();
        chk("R8 exc with enable 1", trap_target, VEC);
        trap_vec = 32'h0000_0200; settle();
        chk("R8 vector follows input", trap_target, 32'h0000_0200);
        rnmi_req = 1; settle();
        chk("R9 rnmi wins collision", trap_target, HADDR);
        step(); idle();
        chk("R6 cleared after collision", {31'b0, nmi_en}, 32'd0);
    endtask

    task automatic t_clear_prio();
        csr_wr_en = 1; csr_wr_nmie = 1; step(); idle();
        chk("R2 set again", {31'b0, nmi_en}, 32'd1);
        rnmi_req = 1; csr_wr_en = 1; csr_wr_nmie = 1; ret_kind = 2'd3; step(); idle();
        chk("R6 clear beats set and resume", {31'b0, nmi_en}, 32'd0);
    endtask

    task automatic t_wake();
        wfi_active = 1; rnmi_req = 1; settle();
        chk("R10 wake with enable 0", {31'b0, wake}, 32'd1);
        chk("R5 no take while waking", {31'b0, take_rnmi}, 32'd0);
        rnmi_req = 0; irq_pending = 1; settle();
        chk("R10 wake on regular irq", {31'b0, wake}, 32'd1);
        irq_pending = 0; settle();
        chk("R10 no wake without pending", {31'b0, wake}, 32'd0);
        wfi_active = 0; rnmi_req = 1; settle();
        chk("R10 no wake outside wfi", {31'b0, wake}, 32'd0);
        idle();
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        trap_vec = VEC;
        do_reset();
        t_csr();
        t_xret();
        t_take();
        t_exc();
        t_clear_prio();
        t_wake();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule